// File: doc/BRIEF.md
# Variable Latency I/O Read Sequencer

This block is the read engine of a memory controller port that talks to a slow peripheral whose access time is not fixed. A request names a starting word address and whether one beat or four beats are wanted. The sequencer then drives the strobes of an asynchronous-style parallel bus in a fixed order: first the address, then chip select, then output enable. It stretches each output-enable pulse until the peripheral signals ready, and captures one 32-bit data word per beat.

Three 4-bit timing inputs shape the access. The first sets the minimum output-enable width. The second sets the address lead time before each later beat. The third sets the idle recovery gap after a burst. The ready input is synchronized inside the block. A done pulse marks the point where the bus may be used again. The timing inputs must stay constant while a request is in progress.

Top module: `vlio_rd_seq`

## Requirements
- R1: During and after reset, with no request: bus_cs_n, bus_oe_n and bus_we_n are 1, req_ready is 1, and rd_valid and done are 0.
- R2: A request is taken only when req_valid and req_ready are both 1 at a clock edge. In the next cycle req_ready is 0, bus_addr shows req_addr and bus_cs_n is still 1. bus_cs_n goes to 0 one cycle later.
- R3: On the first beat, bus_cs_n stays low for two full cycles before bus_oe_n goes low. This puts bus_oe_n low three cycles after the address appears.
- R4: Each bus_oe_n low pulse lasts cfg_access+1 cycles plus one cycle for each wait. bus_rdy passes through two flops. The synchronized value is examined in the last counted cycle, and again in every wait cycle after it. Each 0 that is seen adds one more cycle.
- R5: bus_data is captured on the edge where bus_oe_n returns to 1. In the following cycle rd_valid is 1 for exactly one cycle, with the captured word on rd_data and the beat number (0 to 3) on rd_beat.
- R6: After each bus_oe_n rise, bus_addr and bus_cs_n=0 are held for one more cycle.
- R7: A request with req_burst=1 reads four beats at word addresses A, A+1, A+2 and A+3, computed modulo 2^AW. A request with req_burst=0 reads one beat at A.
- R8: Between beats of a burst, the incremented address is on the bus for cfg_burst_gap cycles with bus_oe_n=1 and bus_cs_n=0 before bus_oe_n goes low again. A value of 0 acts as 1.
- R9: After the last beat's hold cycle, bus_cs_n is 1 and req_ready is 0 for 2*cfg_recover+1 cycles. Then done is 1 for one cycle, together with req_ready=1.
- R10: At all times bus_we_n=1, bus_rd_wr=1 (read), bus_mask=4'b0000 and bus_addr_lo=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | AW | Start word address |
| req_burst | input | 1 | 1 = four beats, 0 = one beat |
| cfg_access | input | 4 | Minimum output-enable width minus one |
| cfg_burst_gap | input | 4 | Address lead before a later beat's output enable |
| cfg_recover | input | 4 | Recovery gap scale; the gap is 2*value+1 cycles |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low (always 1) |
| bus_rd_wr | output | 1 | Direction, 1 = read |
| bus_mask | output | 4 | Byte masks (always 0000) |
| bus_addr | output | AW | Word address |
| bus_addr_lo | output | 2 | Byte address bits (always 00) |
| bus_rdy | input | 1 | Asynchronous ready from the peripheral |
| bus_data | input | DW | Read data from the peripheral |
| rd_valid | output | 1 | Captured word strobe |
| rd_data | output | DW | Captured word |
| rd_beat | output | 2 | Beat index of the captured word |
| done | output | 1 | Recovery gap finished |

## Verification
The assertions check the ordering rules on every cycle:
- output enable only ever appears inside chip select;
- the address and chip select hold around each output-enable edge;
- two cycles of chip select come before each output enable;
- the strobes are single-cycle.

The exact cycle counts depend on the timing inputs and on the history of ready. These are the output-enable widths, wait cycles, beat address lead, recovery length and the captured data values, and only the bench's scenarios show them. The bench walks each transaction cycle by cycle, across random and directed settings, against a timeline it builds from the ready values it drove two cycles earlier.

// File: rtl/vlio_rd_seq.sv
module vlio_rd_seq #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_burst,
  input  logic [3:0]    cfg_access,
  input  logic [3:0]    cfg_burst_gap,
  input  logic [3:0]    cfg_recover,
  output logic          bus_cs_n,
  output logic          bus_oe_n,
  output logic          bus_we_n,
  output logic          bus_rd_wr,
  output logic [3:0]    bus_mask,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_addr_lo,
  input  logic          bus_rdy,
  input  logic [DW-1:0] bus_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    rd_beat,
  output logic          done
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CSET, S_OE, S_HOLD, S_NEXT, S_RECOV
  } state_t;

  state_t        state;
  logic [4:0]    cnt;
  logic [AW-1:0] addr;
  logic [1:0]    beat, last_beat;
  logic          rdy_s1, rdy_s2;

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  wire [4:0] access_ld = {1'b0, cfg_access};
  wire [4:0] gap_ld    = (cfg_burst_gap == 4'd0) ? 5'd0 : {1'b0, cfg_burst_gap} - 5'd1;
  wire [4:0] recov_ld  = {cfg_recover, 1'b0};

  assign req_ready   = (state == S_IDLE);
  assign bus_cs_n    = !(state == S_CSET || state == S_OE || state == S_HOLD || state == S_NEXT);
  assign bus_oe_n    = (state != S_OE);
  assign bus_we_n    = 1'b1;
  assign bus_rd_wr   = 1'b1;
  assign bus_mask    = 4'b0000;
  assign bus_addr_lo = 2'b00;
  assign bus_addr    = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_s1 <= 1'b0;
      rdy_s2 <= 1'b0;
    end else begin
      rdy_s1 <= bus_rdy;
      rdy_s2 <= rdy_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      addr      <= '0;
      beat      <= '0;
      last_beat <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_beat   <= '0;
      done      <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          addr      <= req_addr;
          beat      <= 2'd0;
          last_beat <= req_burst ? 2'd3 : 2'd0;
          state     <= S_ADDR;
        end
        S_ADDR: begin
          cnt   <= 5'd1;
          state <= S_CSET;
        end
        S_CSET, S_NEXT: begin
          if (cnt == 5'd0) begin
            cnt   <= access_ld;
            state <= S_OE;
          end else begin
            cnt <= cnt - 5'd1;
          end
        end
        S_OE: begin
          if (cnt != 5'd0) begin
            cnt <= cnt - 5'd1;
          end else if (rdy_s2) begin
            rd_data  <= bus_data;
            rd_beat  <= beat;
            rd_valid <= 1'b1;
            state    <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (beat == last_beat) begin
            cnt   <= recov_ld;
            state <= S_RECOV;
          end else begin
            addr  <= addr + ONE;
            beat  <= beat + 2'd1;
            cnt   <= gap_ld;
            state <= S_NEXT;
          end
        end
        S_RECOV: begin
          if (cnt == 5'd0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt <= cnt - 5'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> !bus_cs_n); // R3
  AST_CS_BEFORE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe_n) |-> ($past(bus_cs_n, 1) == 1'b0 && $past(bus_cs_n, 2) == 1'b0)); // R3
  AST_ADDR_BEFORE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> $stable(bus_addr)); // R2
  AST_ADDR_DURING_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n && $past(!bus_oe_n)) |-> $stable(bus_addr)); // R4
  AST_HOLD_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_n) |-> (!bus_cs_n && $stable(bus_addr))); // R6
  AST_VALID_AT_OE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(bus_oe_n)); // R5
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && bus_cs_n && !$past(req_ready))); // R9

endmodule

// File: tb/test_vlio_rd_seq.sv
`timescale 1ns/100ps
module test_vlio_rd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_burst = 1'b0;
  logic [3:0]  cfg_access = '0, cfg_burst_gap = '0, cfg_recover = '0;
  logic        bus_cs_n, bus_oe_n, bus_we_n, bus_rd_wr;
  logic [3:0]  bus_mask;
  logic [23:0] bus_addr;
  logic [1:0]  bus_addr_lo;
  logic        bus_rdy = 1'b1;
  logic [31:0] bus_data = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [1:0]  rd_beat;
  logic        done;

  int checks = 0, errors = 0, cyc = 0;
  bit r_m1 = 1'b1, r_m2 = 1'b1;
  logic [31:0] last_data;
  int rmode = 0;

  always #2.5 clk = ~clk;

  vlio_rd_seq #(.AW(24), .DW(32)) i_vlio_rd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_burst(req_burst), .cfg_access(cfg_access),
    .cfg_burst_gap(cfg_burst_gap), .cfg_recover(cfg_recover),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_rd_wr(bus_rd_wr), .bus_mask(bus_mask), .bus_addr(bus_addr),
    .bus_addr_lo(bus_addr_lo), .bus_rdy(bus_rdy), .bus_data(bus_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_beat(rd_beat), .done(done));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic drive_bus();
    bit nr;
    case (rmode)
      0: nr = 1'b1;
      1: nr = $urandom % 2;
      default: nr = ($urandom % 4) == 0;
    endcase
    r_m2 = r_m1;
    r_m1 = nr;
    bus_rdy = nr;
    bus_data = $urandom;
    last_data = bus_data;
  endtask

  task automatic chk_fixed();
    chk(bus_we_n === 1'b1 && bus_rd_wr === 1'b1 && bus_mask === 4'b0000 && bus_addr_lo === 2'b00,
        "R10", "read-only pins", {bus_we_n, bus_rd_wr, bus_mask, bus_addr_lo}, 8'b11_0000_00);
  endtask

  function automatic int exp_gap(input logic [3:0] n);
    return (n == 4'd0) ? 1 : int'(n);
  endfunction

  task automatic run(input logic [23:0] a, input bit four, input logic [3:0] f,
                     input logic [3:0] n, input logic [3:0] r, input int mode);
    int nb;
    logic [23:0] ea;
    logic [31:0] expd;
    rmode = mode;
    nb = four ? 4 : 1;
    step();
    chk(req_ready === 1'b1 && done === 1'b0, "R2", "idle before request", {req_ready, done}, 2'b10);
    req_valid = 1'b1; req_addr = a; req_burst = four;
    cfg_access = f; cfg_burst_gap = n; cfg_recover = r;
    drive_bus();
    step();
    req_valid = 1'b0; req_addr = ~a;
    chk(req_ready === 1'b0 && bus_cs_n === 1'b1 && bus_oe_n === 1'b1 && bus_addr === a,
        "R2", "address phase", {req_ready, bus_cs_n, bus_oe_n, bus_addr}, {3'b011, a});
    drive_bus();
    for (int i = 0; i < 2; i++) begin
      step();
      chk(bus_cs_n === 1'b0 && bus_oe_n === 1'b1 && bus_addr === a,
          "R3", "cs setup before oe", {bus_cs_n, bus_oe_n, bus_addr}, {2'b01, a});
      drive_bus();
    end
    for (int b = 0; b < nb; b++) begin
      bit ended = 1'b0;
      int k = 0;
      ea = a + 24'(b);
      while (!ended) begin
        step();
        chk(bus_oe_n === 1'b0 && bus_cs_n === 1'b0 && bus_addr === ea,
            "R4", "oe low cycle", {bus_oe_n, bus_cs_n, bus_addr}, {2'b00, ea});
        chk(bus_addr === ea, "R7", "beat address", bus_addr, ea);
        chk_fixed();
        if (k >= int'(f) && r_m2) ended = 1'b1;
        drive_bus();
        if (ended) expd = last_data;
        k++;
        if (k > 400) begin
          chk(1'b0, "R4", "oe pulse never ended", k, f);
          return;
        end
      end
      step();
      chk(bus_oe_n === 1'b1 && bus_cs_n === 1'b0 && bus_addr === ea,
          "R6", "hold after oe", {bus_oe_n, bus_cs_n, bus_addr}, {2'b10, ea});
      chk(rd_valid === 1'b1 && rd_data === expd && rd_beat === 2'(b),
          "R5", "captured word", {rd_valid, rd_beat, rd_data}, {1'b1, 2'(b), expd});
      drive_bus();
      if (b < nb - 1) begin
        for (int i = 0; i < exp_gap(n); i++) begin
          step();
          chk(bus_oe_n === 1'b1 && bus_cs_n === 1'b0 && rd_valid === 1'b0 && bus_addr === ea + 24'd1,
              "R8", "next address lead", {bus_oe_n, bus_cs_n, rd_valid, bus_addr},
              {3'b100, ea + 24'd1});
          drive_bus();
        end
      end
    end
    for (int i = 0; i < 2 * int'(r) + 1; i++) begin
      step();
      chk(bus_cs_n === 1'b1 && bus_oe_n === 1'b1 && req_ready === 1'b0 && done === 1'b0,
          "R9", "recovery gap", {bus_cs_n, bus_oe_n, req_ready, done}, 4'b1100);
      drive_bus();
    end
    step();
    chk(done === 1'b1 && req_ready === 1'b1 && bus_cs_n === 1'b1, "R9", "done pulse",
        {done, req_ready, bus_cs_n}, 3'b111);
    drive_bus();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    chk(bus_cs_n === 1'b1 && bus_oe_n === 1'b1 && bus_we_n === 1'b1 && req_ready === 1'b1 &&
        rd_valid === 1'b0 && done === 1'b0, "R1", "in reset",
        {bus_cs_n, bus_oe_n, bus_we_n, req_ready, rd_valid, done}, 6'b111100);
    rst_n = 1'b1;
    step(); step();
    chk(bus_cs_n === 1'b1 && bus_oe_n === 1'b1 && req_ready === 1'b1 && rd_valid === 1'b0 &&
        done === 1'b0, "R1", "idle after reset",
        {bus_cs_n, bus_oe_n, req_ready, rd_valid, done}, 5'b11100);
    chk_fixed();
    run(24'h000100, 1'b0, 4'd0, 4'd1, 4'd0, 0);
    run(24'h001000, 1'b1, 4'd2, 4'd2, 4'd1, 0);
    run(24'h002000, 1'b1, 4'd1, 4'd0, 4'd0, 1);
    run(24'hFFFFFE, 1'b1, 4'd0, 4'd3, 4'd2, 0);
    run(24'h123456, 1'b1, 4'd15, 4'd15, 4'd15, 2);
    run(24'h000040, 1'b0, 4'd3, 4'd1, 4'd1, 2);
    for (int t = 0; t < 40; t++)
      run(24'($urandom), 1'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), int'($urandom % 3));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule